// File: doc/BRIEF.md
# Timer-Shareable Four-Pin I/O Port

This block is a small bidirectional port of four pads. Software reaches it through a simple register bus. Each pad has its own direction bit and its own output latch. Each pad also has an owner bit, and that bit hands both its output level and its output-enable to an internal timer. A pad handed to the timer ignores the port's latch and direction bits, but those bits can still be written and read back. The pad takes them up again the moment ownership returns to the port.

Every pad's input level passes through a two-flop synchronizer. The synchronized level is what a register read of the level address returns. The same synchronized level is also offered to the timer as its input, whoever is driving the pad. A synchronous master reset leaves every pad as an input with a cleared latch, owned by the port.

Top module: `pinmux_port`

## Requirements
- R1: While and after a synchronous reset (`rst` high), every latch, direction and owner bit is 0, so `pad_oe` is 0 and `pad_out` is 0.
- R2: A bus write (`bus_wr` high) to address 0 loads `bus_wdata` into the output latches at that clock edge; reading address 3 returns the latch contents.
- R3: A bus write to address 1 loads the direction bits (1 = output); for a port-owned pin, `pad_oe[i]` equals its direction bit.
- R4: For a port-owned pin, `pad_out[i]` equals its latch bit, whatever its direction bit.
- R5: For a pin whose owner bit (address 2, 1 = timer) is set, `pad_out[i]` equals `tmr_out[i]` and `pad_oe[i]` equals `tmr_oe[i]`; the latch and direction bits have no effect on that pin.
- R6: Reading address 0 returns `pad_in` delayed by exactly two clock edges.
- R7: `tmr_in` carries `pad_in` delayed by exactly two clock edges, whether the pin is owned by the port or by the timer.
- R8: Latch and direction writes made while a pin is timer-owned are stored and take effect on the pad as soon as its owner bit returns to 0.
- R9: Reading address 1 returns the direction bits and reading address 2 returns the owner bits.
- R10: A bus write to address 3 changes no register and no pad output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 level/latch, 1 direction, 2 owner, 3 latch readback) |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for `bus_addr` (combinational) |
| pad_in | input | NPINS | Pad input levels |
| pad_out | output | NPINS | Pad output levels |
| pad_oe | output | NPINS | Pad output-enables (1 = drive) |
| tmr_out | input | NPINS | Timer output levels |
| tmr_oe | input | NPINS | Timer output-enables |
| tmr_in | output | NPINS | Synchronized pad levels to the timer |

## Verification
The bench builds the block with its defaults: four pins and a two-stage synchronizer. At that size every combination of latch, direction and owner bits can be swept, which covers all 4096 register states against two timer drive patterns per state. All sixteen pad input values are stepped through in sequence with every pin owned first by the port and then by the timer. This checks the one-edge "not yet" sample and the two-edge "arrived" sample on both the read path and the timer input.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

    localparam int unsigned REG_ADDR_W = 2;

    // Register map; the decode of these offsets is the bus contract.
    typedef enum logic [REG_ADDR_W-1:0] {
        REG_LEVEL = 2'd0,   // write: output latch, read: synchronized pads
        REG_DIR   = 2'd1,   // pad direction, 1 = output
        REG_OWNER = 2'd2,   // pad owner, 1 = timer
        REG_LATCH = 2'd3    // read-only view of the output latch
    } reg_sel_e;

    typedef enum logic {
        OWN_PORT  = 1'b0,
        OWN_TIMER = 1'b1
    } pin_owner_e;

    // One pad's drive request: level and output-enable travel together.
    typedef struct packed {
        logic drive;
        logic level;
    } pin_drv_t;

    // Both multiplexers of a pad share one select, so they switch as a pair.
    function automatic pin_drv_t pick_driver(
        input pin_owner_e owner,
        input pin_drv_t   port_side,
        input pin_drv_t   timer_side
    );
        pin_drv_t res;
        if (owner == OWN_TIMER) begin
            res = timer_side;
        end else begin
            res = port_side;
        end
        return res;
    endfunction

endpackage

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    localparam int unsigned DEPTH = (STAGES < 1) ? 1 : STAGES;

    logic [DEPTH-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d;
            for (int s = 1; s < int'(DEPTH); s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q = chain_q[DEPTH-1];

endmodule

// File: rtl/pinmux_regs.sv
module pinmux_regs
    import pinmux_pkg::*;
#(
    parameter int unsigned NPINS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]      bus_wdata,
    input  logic [NPINS-1:0]      level_sync,
    output logic [NPINS-1:0]      bus_rdata,
    output logic [NPINS-1:0]      latch_q,
    output logic [NPINS-1:0]      dir_q,
    output logic [NPINS-1:0]      own_q
);

    reg_sel_e sel;
    logic     wr_latch;
    logic     wr_dir;
    logic     wr_own;

    assign sel = reg_sel_e'(bus_addr);

    always_comb begin
        wr_latch = 1'b0;
        wr_dir   = 1'b0;
        wr_own   = 1'b0;
        if (bus_wr) begin
            unique case (sel)
                REG_LEVEL: wr_latch = 1'b1;
                REG_DIR:   wr_dir   = 1'b1;
                REG_OWNER: wr_own   = 1'b1;
                default:   ;   // the readback offset takes no write
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '0;
            own_q   <= '0;
        end else begin
            if (wr_latch) latch_q <= bus_wdata;
            if (wr_dir)   dir_q   <= bus_wdata;
            if (wr_own)   own_q   <= bus_wdata;
        end
    end

    always_comb begin
        unique case (sel)
            REG_LEVEL: bus_rdata = level_sync;
            REG_DIR:   bus_rdata = dir_q;
            REG_OWNER: bus_rdata = own_q;
            default:   bus_rdata = latch_q;
        endcase
    end

endmodule

// File: rtl/pinmux_lane.sv
module pinmux_lane
    import pinmux_pkg::*;
(
    input  logic own_timer,
    input  logic port_level,
    input  logic port_drive,
    input  logic tmr_level,
    input  logic tmr_drive,
    output logic pad_level,
    output logic pad_drive
);

    pin_drv_t port_side;
    pin_drv_t tmr_side;
    pin_drv_t chosen;

    always_comb begin
        port_side = '{drive: port_drive, level: port_level};
        tmr_side  = '{drive: tmr_drive,  level: tmr_level};
        chosen    = pick_driver(pin_owner_e'(own_timer), port_side, tmr_side);
    end

    assign pad_level = chosen.level;
    assign pad_drive = chosen.drive;

endmodule

// File: rtl/pinmux_port.sv
module pinmux_port
    import pinmux_pkg::*;
#(
    parameter int unsigned NPINS       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]      bus_wdata,
    output logic [NPINS-1:0]      bus_rdata,
    input  logic [NPINS-1:0]      pad_in,
    output logic [NPINS-1:0]      pad_out,
    output logic [NPINS-1:0]      pad_oe,
    input  logic [NPINS-1:0]      tmr_out,
    input  logic [NPINS-1:0]      tmr_oe,
    output logic [NPINS-1:0]      tmr_in
);

    logic [NPINS-1:0] latch_q;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] own_q;
    logic [NPINS-1:0] level_sync;

    pinmux_sync #(
        .WIDTH  (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (level_sync)
    );

    pinmux_regs #(
        .NPINS (NPINS)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .level_sync (level_sync),
        .bus_rdata  (bus_rdata),
        .latch_q    (latch_q),
        .dir_q      (dir_q),
        .own_q      (own_q)
    );

    generate
        for (genvar i = 0; i < int'(NPINS); i++) begin : g_lane
            pinmux_lane u_lane (
                .own_timer  (own_q[i]),
                .port_level (latch_q[i]),
                .port_drive (dir_q[i]),
                .tmr_level  (tmr_out[i]),
                .tmr_drive  (tmr_oe[i]),
                .pad_level  (pad_out[i]),
                .pad_drive  (pad_oe[i])
            );
        end
    endgenerate

    // The timer sees the same synchronized level as the read path.
    assign tmr_in = level_sync;

endmodule

// File: rtl/pinmux_port_chk.sv
module pinmux_port_chk
    import pinmux_pkg::*;
#(
    parameter int unsigned NPINS       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_wr,
    input logic [REG_ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]      bus_wdata,
    input logic [NPINS-1:0]      pad_in,
    input logic [NPINS-1:0]      pad_out,
    input logic [NPINS-1:0]      pad_oe,
    input logic [NPINS-1:0]      tmr_out,
    input logic [NPINS-1:0]      tmr_oe,
    input logic [NPINS-1:0]      tmr_in,
    input logic [NPINS-1:0]      latch_q,
    input logic [NPINS-1:0]      dir_q,
    input logic [NPINS-1:0]      own_q
);

    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= '0;
        end else if (age_q != 2'd2) begin
            age_q <= age_q + 2'd1;
        end
    end

    // R1
    reset_safe_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && latch_q == '0 && own_q == '0 && dir_q == '0));

    // R2
    latch_load_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_LEVEL) |=> (latch_q == $past(bus_wdata)));

    // R3
    dir_to_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_DIR) |=> (((pad_oe ^ $past(bus_wdata)) & ~own_q) == '0));

    // R5
    timer_owns_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (((pad_out ^ tmr_out) & own_q) == '0) && (((pad_oe ^ tmr_oe) & own_q) == '0));

    // R10
    readback_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_LATCH) |=> ($stable(latch_q) && $stable(dir_q) && $stable(own_q)));

    generate
        if (SYNC_STAGES == 2) begin : g_sync2
            // R7
            timer_input_delay_chk: assert property (@(posedge clk) disable iff (rst)
                (age_q == 2'd2) |-> (tmr_in == $past(pad_in, 2)));
        end
    endgenerate

endmodule

bind pinmux_port pinmux_port_chk #(
    .NPINS       (NPINS),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .tmr_out   (tmr_out),
    .tmr_oe    (tmr_oe),
    .tmr_in    (tmr_in),
    .latch_q   (latch_q),
    .dir_q     (dir_q),
    .own_q     (own_q)
);

// File: tb/tb_pinmux_port.sv
module tb_pinmux_port;

    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_wr;
    logic [1:0]    bus_addr;
    logic [NP-1:0] bus_wdata;
    logic [NP-1:0] bus_rdata;
    logic [NP-1:0] pad_in;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic [NP-1:0] tmr_out;
    logic [NP-1:0] tmr_oe;
    logic [NP-1:0] tmr_in;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    pinmux_port dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .tmr_out   (tmr_out),
        .tmr_oe    (tmr_oe),
        .tmr_in    (tmr_in)
    );

    task automatic check(input string req, input string what,
                         input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [NP-1:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [NP-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [NP-1:0] rd;
        logic [NP-1:0] prev;
        logic [NP-1:0] t_o;
        logic [NP-1:0] t_e;

        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        pad_in = '0; tmr_out = 4'hF; tmr_oe = 4'hF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1", "pad_oe after reset", pad_oe, 4'h0);
        check("R1", "pad_out after reset", pad_out, 4'h0);
        rd_reg(2'd3, rd); check("R1", "latch after reset", rd, 4'h0);
        rd_reg(2'd1, rd); check("R1", "dir after reset", rd, 4'h0);
        rd_reg(2'd2, rd); check("R1", "owner after reset", rd, 4'h0);

        // Exhaustive sweep of latch x direction x owner
        for (int l = 0; l < 16; l++) begin
            for (int d = 0; d < 16; d++) begin
                for (int o = 0; o < 16; o++) begin
                    wr_reg(2'd0, NP'(l));
                    wr_reg(2'd1, NP'(d));
                    wr_reg(2'd2, NP'(o));
                    rd_reg(2'd3, rd); check("R2", "latch readback", rd, NP'(l));
                    rd_reg(2'd1, rd); check("R9", "dir readback", rd, NP'(d));
                    rd_reg(2'd2, rd); check("R9", "owner readback", rd, NP'(o));
                    for (int p = 0; p < 2; p++) begin
                        t_o = (p == 0) ? 4'h5 : (NP'(l) ^ 4'hF);
                        t_e = (p == 0) ? 4'hA : (NP'(d) ^ 4'h3);
                        tmr_out = t_o;
                        tmr_oe  = t_e;
                        #1;
                        check("R4 R5", "pad_out", pad_out,
                              (NP'(o) & t_o) | (~NP'(o) & NP'(l)));
                        check("R3 R5", "pad_oe", pad_oe,
                              (NP'(o) & t_e) | (~NP'(o) & NP'(d)));
                    end
                end
            end
        end

        // R8: writes while timer-owned take effect on release
        tmr_out = 4'h3; tmr_oe = 4'hC;
        wr_reg(2'd2, 4'hF);
        wr_reg(2'd0, 4'hA);
        wr_reg(2'd1, 4'h6);
        check("R5", "pad_out timer-owned", pad_out, 4'h3);
        check("R5", "pad_oe timer-owned", pad_oe, 4'hC);
        rd_reg(2'd3, rd); check("R8", "latch stored while owned", rd, 4'hA);
        wr_reg(2'd2, 4'h0);
        check("R8", "pad_out after release", pad_out, 4'hA);
        check("R8", "pad_oe after release", pad_oe, 4'h6);

        // R10: readback offset ignores writes
        wr_reg(2'd3, 4'h5);
        rd_reg(2'd3, rd); check("R10", "latch unchanged", rd, 4'hA);
        rd_reg(2'd1, rd); check("R10", "dir unchanged", rd, 4'h6);
        rd_reg(2'd2, rd); check("R10", "owner unchanged", rd, 4'h0);
        check("R10", "pad_out unchanged", pad_out, 4'hA);
        check("R10", "pad_oe unchanged", pad_oe, 4'h6);

        // R6 / R7: synchronizer latency under both owners
        for (int own = 0; own < 2; own++) begin
            wr_reg(2'd2, (own == 0) ? 4'h0 : 4'hF);
            bus_addr = 2'd0;
            pad_in = '0;
            repeat (3) @(negedge clk);
            prev = '0;
            for (int v = 15; v >= 0; v--) begin
                pad_in = NP'(v) ^ 4'h9;
                @(negedge clk);
                #1;
                check("R6", "read after one edge", bus_rdata, prev);
                check("R7", "tmr_in after one edge", tmr_in, prev);
                @(negedge clk);
                #1;
                check("R6", "read after two edges", bus_rdata, NP'(v) ^ 4'h9);
                check("R7", "tmr_in after two edges", tmr_in, NP'(v) ^ 4'h9);
                prev = NP'(v) ^ 4'h9;
            end
        end

        // R1: reset in mid-run clears configuration
        wr_reg(2'd0, 4'hF);
        wr_reg(2'd1, 4'hF);
        wr_reg(2'd2, 4'h5);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "pad_oe after mid reset", pad_oe, 4'h0);
        check("R1", "pad_out after mid reset", pad_out, 4'h0);
        rd_reg(2'd2, rd); check("R1", "owner after mid reset", rd, 4'h0);

        finish_run();
    end

endmodule